// File: doc/BRIEF.md
# Parallel Master Port Engine

This block is the master side of a parallel data port. It moves 16-bit words between an internal pair of eight-entry buffers and an external data bus. The bus can be 8 or 16 bits wide, and either byte lane of the 16-bit pins can carry the narrow case. One timing generator, stepped by a clock prescaler, makes a single active-low strobe waveform. A per-pin enable mask places that waveform on any subset of the control outputs. In output mode the engine drives each word or byte onto the pins as its transfer cycle starts. In input mode it releases the pins and captures them, either as the strobe rises or as the cycle ends.

The two buffers alternate between the host and the engine. The host fills one buffer, or reads one back, while the engine drains or fills the other. The host hands a buffer over with a one-cycle flip pulse, and the engine hands it back by itself when it finishes with it. When the next buffer is not yet available, the engine parks with the strobe inactive and raises a stall flag. It resumes by itself once the host supplies the buffer. An optional stage exchanges the two bytes of every word on the way between the buffers and the pins.

Top module: `par_port_engine`

## Requirements
- R1: After synchronous reset, every control pin is high, the data pins carry zero, both buffer-valid bits and both stall flags are low, and the host and the engine both point at buffer 0.
- R2: `cfg_lane` selects the bus width. 0 carries bytes on `pad_dout[7:0]`/`pad_din[7:0]`, 1 carries them on bits 15:8, and 2 carries full words. In an 8-bit output mode the unused lane is driven as zero.
- R3: With `cfg_dir`=1 the pins are driven (`pad_oe`=1). The value of each transfer appears on `pad_dout` in the clock that starts its strobe-low phase and holds through that phase.
- R4: The strobe stays low for (`cfg_low_len`+1)·(`cfg_prescale`+1) clocks and then high for (`cfg_high_len`+1)·(`cfg_prescale`+1) clocks. Consecutive transfers follow each other with no gap.
- R5: Control pin i carries the strobe when `cfg_pin_en[i]`=1 and stays high otherwise.
- R6: With `cfg_dir`=0, `pad_oe` is low. If `cfg_cap_edge`=1, `pad_din` is captured at the clock that ends the low phase (the rising strobe). If it is 0, capture happens at the clock that ends the high phase.
- R7: In 8-bit modes each buffer entry is two transfers, low byte first. A buffer is handed back after 16 byte transfers, or after 8 word transfers in 16-bit mode.
- R8: A `host_flip` pulse toggles the valid bit of the host's buffer and moves the host to the other buffer. The engine works only on a buffer that is valid (output) or not valid (input). When it finishes a buffer, it toggles that buffer's valid bit and moves on.
- R9: With `cfg_swap`=1 the two bytes of every word are exchanged between the buffer and the pins, in both directions.
- R10: When a buffer finishes and the next one is not available while `run`=1, the engine waits with all control pins high. During the wait it holds `underrun` (output) or `overrun` (input). It restarts, clearing the flag, as soon as that buffer becomes available.
- R11: Dropping `run` lets the current transfer finish and then stops without a flag. Raising it again continues from the next position in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables transfers |
| cfg_dir | input | 1 | 1 = output to pins, 0 = input from pins |
| cfg_lane | input | 2 | Lane/width select (0 low byte, 1 high byte, 2 word) |
| cfg_swap | input | 1 | Exchange bytes of each word |
| cfg_cap_edge | input | 1 | Input capture point: 1 rising strobe, 0 cycle end |
| cfg_prescale | input | PRE_W | Prescaler divide minus one |
| cfg_low_len | input | DUR_W | Strobe-low ticks minus one |
| cfg_high_len | input | DUR_W | Strobe-high ticks minus one |
| cfg_pin_en | input | PINS | Control pins that carry the strobe |
| host_we | input | 1 | Host write strobe into its buffer |
| host_addr | input | IDX_W | Host write entry |
| host_wdata | input | 16 | Host write word |
| host_raddr | input | IDX_W | Host read entry |
| host_rdata | output | 16 | Host read word from its buffer |
| host_flip | input | 1 | Hand the host buffer over and switch |
| buf_valid | output | 2 | Valid bit of each buffer |
| underrun | output | 1 | Output engine waiting for data |
| overrun | output | 1 | Input engine waiting for space |
| pad_din | input | 16 | Data pins, input value |
| pad_dout | output | 16 | Data pins, output value |
| pad_oe | output | 1 | Data pin output enable |
| ctrl_out | output | PINS | Control pins, active-low strobe |

## Verification
Some properties are checked by the assertions on every cycle. All control pins stay high while a stall flag is set. The driven data does not move during a strobe-low phase. The unused byte lane stays zero in low-lane output mode. The engine never hands back a buffer it was not entitled to use, and the prescaler count never passes its limit. Other behaviour can only be shown by the bench's scenarios, run over a table of directions, lanes, swap settings and timings. These cover the byte order within words and across buffers, the exact phase lengths, and which edge input capture uses. They also cover the stop at a transfer boundary, the restart after a stall, and the exact pin pattern under a partial mask.

// File: rtl/par_port_pkg.sv
package par_port_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        LANE_LOW  = 2'b00,
        LANE_HIGH = 2'b01,
        LANE_WIDE = 2'b10
    } lane_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_HIGH = 2'b10
    } phase_e;

    typedef struct packed {
        logic  dir;
        lane_e lane;
        logic  swap;
        logic  cap_edge;
    } mode_t;

    function automatic logic [WORD_W-1:0] swap16(input logic [WORD_W-1:0] w);
        return {w[BYTE_W-1:0], w[WORD_W-1:BYTE_W]};
    endfunction

    function automatic logic [WORD_W-1:0] opt_swap(input logic [WORD_W-1:0] w, input logic en);
        return en ? swap16(w) : w;
    endfunction

    // Place one transfer of a word onto the pins for the chosen lane.
    function automatic logic [WORD_W-1:0] place_lane(input logic [WORD_W-1:0] w,
                                                     input logic upper, input lane_e lane);
        logic [BYTE_W-1:0] b;
        b = upper ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
        case (lane)
            LANE_LOW:  return {{BYTE_W{1'b0}}, b};
            LANE_HIGH: return {b, {BYTE_W{1'b0}}};
            default:   return w;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] pick_lane(input logic [WORD_W-1:0] d, input lane_e lane);
        return (lane == LANE_HIGH) ? d[WORD_W-1:BYTE_W] : d[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/par_port_timing.sv
module par_port_timing
    import par_port_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int DUR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PRE_W-1:0] pre,
    input  logic [DUR_W-1:0] low_n,
    input  logic [DUR_W-1:0] high_n,
    output logic             active,
    output logic             strobe_low,
    output logic             rise,
    output logic             done
);

    phase_e           ph;
    logic [DUR_W-1:0] cnt;
    logic [PRE_W-1:0] pc;
    logic             tick;

    assign tick       = (pc == pre);
    assign rise       = (ph == PH_LOW)  && tick && (cnt == low_n);
    assign done       = (ph == PH_HIGH) && tick && (cnt == high_n);
    assign active     = (ph != PH_IDLE);
    assign strobe_low = (ph == PH_LOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
            pc  <= '0;
        end else if (start) begin
            ph  <= PH_LOW;
            cnt <= '0;
            pc  <= '0;
        end else if (ph != PH_IDLE) begin
            pc <= tick ? '0 : pc + 1'b1;
            if (tick) begin
                if (rise) begin
                    ph  <= PH_HIGH;
                    cnt <= '0;
                end else if (done) begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: the prescaler count never runs past its limit during a phase
    assert_tick_bound_R4: assert property (@(posedge clk) disable iff (rst)
        active |-> (pc <= pre));

endmodule

// File: rtl/par_port_buffers.sv
module par_port_buffers
    import par_port_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [IDX_W-1:0]  host_raddr,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              host_flip,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_waddr,
    input  logic [WORD_W-1:0] eng_wdata,
    input  logic              eng_rsel,
    input  logic [IDX_W-1:0]  eng_raddr,
    output logic [WORD_W-1:0] eng_rdata,
    input  logic              eng_complete,
    output logic              eng_ptr,
    output logic [1:0]        valid,
    output logic [1:0]        ready
);

    logic [WORD_W-1:0] mem [2][DEPTH];
    logic              hptr;
    logic [1:0]        valid_nx;

    assign ready      = dir ? valid : ~valid;
    assign host_rdata = mem[hptr][host_raddr];
    assign eng_rdata  = mem[eng_rsel][eng_raddr];

    always_comb begin
        valid_nx = valid;
        if (host_flip)    valid_nx[hptr]    = ~valid[hptr];
        if (eng_complete) valid_nx[eng_ptr] = ~valid[eng_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= '0;
            hptr    <= 1'b0;
            eng_ptr <= 1'b0;
        end else begin
            valid <= valid_nx;
            if (host_flip)    hptr    <= ~hptr;
            if (eng_complete) eng_ptr <= ~eng_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (host_we) mem[hptr][host_addr]    <= host_wdata;
        if (eng_we)  mem[eng_ptr][eng_waddr] <= eng_wdata;
    end

    // R8: the engine only hands back a buffer it was entitled to use
    assert_complete_ready_R8: assert property (@(posedge clk) disable iff (rst)
        eng_complete |-> ready[eng_ptr]);

endmodule

// File: rtl/par_port_engine.sv
module par_port_engine
    import par_port_pkg::*;
#(
    parameter int PINS  = 8,
    parameter int DEPTH = 8,
    parameter int PRE_W = 8,
    parameter int DUR_W = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              cfg_dir,
    input  logic [1:0]        cfg_lane,
    input  logic              cfg_swap,
    input  logic              cfg_cap_edge,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [DUR_W-1:0]  cfg_low_len,
    input  logic [DUR_W-1:0]  cfg_high_len,
    input  logic [PINS-1:0]   cfg_pin_en,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [15:0]       host_wdata,
    input  logic [IDX_W-1:0]  host_raddr,
    output logic [15:0]       host_rdata,
    input  logic              host_flip,
    output logic [1:0]        buf_valid,
    output logic              underrun,
    output logic              overrun,
    input  logic [15:0]       pad_din,
    output logic [15:0]       pad_dout,
    output logic              pad_oe,
    output logic [PINS-1:0]   ctrl_out
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    mode_t             mode;
    logic              wide;
    logic              active, strobe_low, rise, done, start;
    logic              eptr, n_sel, last;
    logic [1:0]        ready;
    logic [IDX_W-1:0]  widx, adv_idx, n_idx;
    logic              sub, adv_sub, n_sub;
    logic [WORD_W-1:0] eng_rdata, eng_wdata, dout;
    logic [BYTE_W-1:0] lo_byte, cap_byte;
    logic              capture, eng_we, stall;

    assign mode = '{dir: cfg_dir, lane: lane_e'(cfg_lane), swap: cfg_swap, cap_edge: cfg_cap_edge};
    assign wide = (mode.lane != LANE_LOW) && (mode.lane != LANE_HIGH);

    // Position bookkeeping inside the active buffer
    assign last    = (widx == LAST_IDX) && (wide || sub);
    assign adv_sub = wide ? 1'b0 : ~sub;
    assign adv_idx = (wide || sub) ? ((widx == LAST_IDX) ? '0 : widx + 1'b1) : widx;
    assign n_sel   = (done && last) ? ~eptr : eptr;
    assign n_idx   = done ? adv_idx : widx;
    assign n_sub   = done ? adv_sub : sub;
    assign start   = run && (!active || done) && ready[n_sel];

    // Input capture path
    assign capture   = !mode.dir && (mode.cap_edge ? rise : done);
    assign cap_byte  = pick_lane(pad_din, mode.lane);
    assign eng_we    = capture && (wide || sub);
    assign eng_wdata = opt_swap(wide ? pad_din : {cap_byte, lo_byte}, mode.swap);

    par_port_timing #(.PRE_W(PRE_W), .DUR_W(DUR_W)) u_timing (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pre        (cfg_prescale),
        .low_n      (cfg_low_len),
        .high_n     (cfg_high_len),
        .active     (active),
        .strobe_low (strobe_low),
        .rise       (rise),
        .done       (done)
    );

    par_port_buffers #(.DEPTH(DEPTH)) u_bufs (
        .clk          (clk),
        .rst          (rst),
        .dir          (mode.dir),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_raddr   (host_raddr),
        .host_rdata   (host_rdata),
        .host_flip    (host_flip),
        .eng_we       (eng_we),
        .eng_waddr    (widx),
        .eng_wdata    (eng_wdata),
        .eng_rsel     (n_sel),
        .eng_raddr    (n_idx),
        .eng_rdata    (eng_rdata),
        .eng_complete (done && last),
        .eng_ptr      (eptr),
        .valid        (buf_valid),
        .ready        (ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            widx    <= '0;
            sub     <= 1'b0;
            dout    <= '0;
            lo_byte <= '0;
            stall   <= 1'b0;
        end else begin
            if (done) begin
                widx <= adv_idx;
                sub  <= adv_sub;
            end
            if (start && mode.dir)
                dout <= place_lane(opt_swap(eng_rdata, mode.swap), n_sub, mode.lane);
            if (capture && !wide && !sub)
                lo_byte <= cap_byte;
            if (start)
                stall <= 1'b0;
            else if (done && run)
                stall <= 1'b1;
            else if (!run)
                stall <= 1'b0;
        end
    end

    assign underrun = stall && mode.dir;
    assign overrun  = stall && !mode.dir;
    assign pad_oe   = mode.dir;
    assign pad_dout = mode.dir ? dout : '0;
    assign ctrl_out = {PINS{~strobe_low}} | ~cfg_pin_en;

    // R10: a waiting engine keeps every control pin inactive
    assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (underrun || overrun) |-> (ctrl_out == {PINS{1'b1}}));

    // R3: driven data does not move while the strobe is low
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mode.dir && strobe_low && $past(strobe_low)) |-> $stable(pad_dout));

    // R2: unused upper lane stays zero in low-lane output mode
    assert_lane_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (mode.dir && mode.lane == LANE_LOW) |-> (pad_dout[15:8] == 8'h00));

endmodule

// File: tb/par_port_engine_test.sv
module par_port_engine_test;

    typedef struct packed {
        logic       dir;
        logic [1:0] lane;
        logic       swp;
        logic       edg;
        logic [7:0] pre;
        logic [3:0] lo;
        logic [3:0] hi;
    } scen_t;

    localparam int NSCEN = 6;
    localparam scen_t SCEN [NSCEN] = '{
        '{1'b1, 2'd2, 1'b0, 1'b0, 8'd0, 4'd0, 4'd0},
        '{1'b1, 2'd0, 1'b1, 1'b0, 8'd0, 4'd2, 4'd1},
        '{1'b1, 2'd1, 1'b0, 1'b0, 8'd1, 4'd0, 4'd3},
        '{1'b0, 2'd2, 1'b1, 1'b0, 8'd0, 4'd1, 4'd0},
        '{1'b0, 2'd0, 1'b0, 1'b1, 8'd2, 4'd0, 4'd2},
        '{1'b0, 2'd1, 1'b1, 1'b0, 8'd0, 4'd3, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst, run, cfg_dir, cfg_swap, cfg_cap_edge;
    logic [1:0]  cfg_lane;
    logic [7:0]  cfg_prescale, cfg_pin_en;
    logic [3:0]  cfg_low_len, cfg_high_len;
    logic        host_we, host_flip;
    logic [2:0]  host_addr, host_raddr;
    logic [15:0] host_wdata, host_rdata, pad_din, pad_dout;
    logic [1:0]  buf_valid;
    logic        underrun, overrun, pad_oe;
    logic [7:0]  ctrl_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    par_port_engine uut (
        .clk(clk), .rst(rst), .run(run), .cfg_dir(cfg_dir), .cfg_lane(cfg_lane),
        .cfg_swap(cfg_swap), .cfg_cap_edge(cfg_cap_edge), .cfg_prescale(cfg_prescale),
        .cfg_low_len(cfg_low_len), .cfg_high_len(cfg_high_len), .cfg_pin_en(cfg_pin_en),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata), .host_flip(host_flip),
        .buf_valid(buf_valid), .underrun(underrun), .overrun(overrun),
        .pad_din(pad_din), .pad_dout(pad_dout), .pad_oe(pad_oe), .ctrl_out(ctrl_out)
    );

    // ---------------- pin monitor and input responder ----------------
    function automatic logic [15:0] pat(input int t);
        logic [7:0] b;
        b = 8'(t);
        return {b ^ 8'hC3, b + 8'h21};
    endfunction

    int          n_tx = 0;
    int          lcnt = 0;
    int          hcnt = 0;
    logic        prev_s = 1'b1;
    logic [15:0] log_d  [64];
    int          lo_len [64];
    int          hi_len [64];

    always @(negedge clk) begin
        if (prev_s && !ctrl_out[0]) begin
            log_d[n_tx % 64] = pad_dout;
            if (n_tx > 0) hi_len[(n_tx - 1) % 64] = hcnt;
            pad_din = pat(n_tx);
            lcnt = 1;
            n_tx = n_tx + 1;
        end else if (!prev_s && ctrl_out[0]) begin
            lo_len[(n_tx - 1) % 64] = lcnt;
            pad_din = ~pat(n_tx - 1);
            hcnt = 1;
        end else if (!ctrl_out[0]) begin
            lcnt = lcnt + 1;
        end else begin
            hcnt = hcnt + 1;
        end
        prev_s = ctrl_out[0];
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] wordv(input int s, input int i);
        return 16'((s + 1) * 4369) ^ 16'(i * 2311 + 57);
    endfunction

    function automatic logic [15:0] sw(input logic [15:0] w, input logic en);
        return en ? {w[7:0], w[15:8]} : w;
    endfunction

    function automatic logic [15:0] out_exp(input logic [15:0] w, input logic upper,
                                            input logic [1:0] lane, input logic swp);
        logic [15:0] v;
        logic [7:0]  b;
        v = sw(w, swp);
        b = upper ? v[15:8] : v[7:0];
        if (lane == 2'd0) return {8'h00, b};
        if (lane == 2'd1) return {b, 8'h00};
        return v;
    endfunction

    function automatic logic [15:0] cap_val(input int t, input logic edg);
        return edg ? pat(t) : ~pat(t);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        run = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_write(input int a, input logic [15:0] d);
        host_we = 1'b1;
        host_addr = 3'(a);
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic flip();
        host_flip = 1'b1;
        @(negedge clk);
        host_flip = 1'b0;
    endtask

    task automatic wait_tx(input int target);
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (n_tx >= target) break;
        end
        @(negedge clk);
    endtask

    task automatic wait_stall();
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            if (underrun || overrun) break;
        end
    endtask

    task automatic set_cfg(input scen_t c);
        cfg_dir = c.dir;
        cfg_lane = c.lane;
        cfg_swap = c.swp;
        cfg_cap_edge = c.edg;
        cfg_prescale = c.pre;
        cfg_low_len = c.lo;
        cfg_high_len = c.hi;
    endtask

    // ---------------- one table scenario ----------------
    task automatic run_scen(input int s);
        scen_t       c;
        int          base, per, e, t0;
        logic        up;
        logic [15:0] exp, v;
        c = SCEN[s];
        set_cfg(c);
        cfg_pin_en = 8'hFF;
        do_reset();
        base = n_tx;
        per = (c.lane == 2'd2) ? 8 : 16;
        if (c.dir) begin
            for (int i = 0; i < 8; i++) host_write(i, wordv(s, i));
            flip();
            chk(buf_valid == 2'b01, "R8 commit", 32'(buf_valid), 32'h1);
            run = 1'b1;
            wait_tx(base + per);
            wait_stall();
            chk(underrun == 1'b1, "R10 underrun", 32'(underrun), 32'h1);
            chk(ctrl_out == 8'hFF, "R10 pins idle", 32'(ctrl_out), 32'hFF);
            chk(buf_valid == 2'b00, "R8 handback", 32'(buf_valid), 32'h0);
            chk(pad_oe == 1'b1, "R3 oe", 32'(pad_oe), 32'h1);
            @(posedge clk);
            chk(n_tx == base + per, "R7 count", 32'(n_tx - base), 32'(per));
            for (int k = 0; k < per; k++) begin
                e  = (per == 8) ? k : k / 2;
                up = (per == 8) ? 1'b0 : 1'(k % 2);
                exp = out_exp(wordv(s, e), up, c.lane, c.swp);
                chk(log_d[(base + k) % 64] == exp, "R3 R2 R7 R9 data",
                    32'(log_d[(base + k) % 64]), 32'(exp));
                chk(lo_len[(base + k) % 64] == (c.lo + 1) * (c.pre + 1), "R4 low",
                    32'(lo_len[(base + k) % 64]), 32'((c.lo + 1) * (c.pre + 1)));
                if (k < per - 1)
                    chk(hi_len[(base + k) % 64] == (c.hi + 1) * (c.pre + 1), "R4 high",
                        32'(hi_len[(base + k) % 64]), 32'((c.hi + 1) * (c.pre + 1)));
            end
        end else begin
            chk(pad_oe == 1'b0, "R6 oe", 32'(pad_oe), 32'h0);
            run = 1'b1;
            wait_stall();
            chk(overrun == 1'b1, "R10 overrun", 32'(overrun), 32'h1);
            chk(ctrl_out == 8'hFF, "R10 pins idle", 32'(ctrl_out), 32'hFF);
            chk(buf_valid == 2'b11, "R8 both full", 32'(buf_valid), 32'h3);
            run = 1'b0;
            @(negedge clk);
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < 8; i++) begin
                    if (per == 8) begin
                        exp = sw(cap_val(base + b * 8 + i, c.edg), c.swp);
                    end else begin
                        t0 = base + b * 16 + 2 * i;
                        v = {c.lane == 2'd1 ? cap_val(t0 + 1, c.edg) >> 8 : cap_val(t0 + 1, c.edg) & 16'h00FF};
                        exp[15:8] = v[7:0];
                        v = {c.lane == 2'd1 ? cap_val(t0, c.edg) >> 8 : cap_val(t0, c.edg) & 16'h00FF};
                        exp[7:0] = v[7:0];
                        exp = sw(exp, c.swp);
                    end
                    host_raddr = 3'(i);
                    #1;
                    chk(host_rdata == exp, "R6 R2 R7 R9 capture", 32'(host_rdata), 32'(exp));
                end
                flip();
            end
            chk(buf_valid == 2'b00, "R8 released", 32'(buf_valid), 32'h0);
        end
        run = 1'b0;
    endtask

    // ---------------- directed tests ----------------
    task automatic test_reset();
        cfg_dir = 1'b0;
        cfg_lane = 2'd2;
        cfg_swap = 1'b0;
        cfg_cap_edge = 1'b0;
        cfg_prescale = 8'd0;
        cfg_low_len = 4'd0;
        cfg_high_len = 4'd0;
        cfg_pin_en = 8'hFF;
        do_reset();
        chk(ctrl_out == 8'hFF, "R1 pins", 32'(ctrl_out), 32'hFF);
        chk(pad_oe == 1'b0 && pad_dout == 16'h0, "R1 data", 32'({pad_oe, pad_dout}), 32'h0);
        chk(buf_valid == 2'b00, "R1 valid", 32'(buf_valid), 32'h0);
        chk(!underrun && !overrun, "R1 flags", 32'({underrun, overrun}), 32'h0);
    endtask

    task automatic test_pin_mask();
        set_cfg('{1'b1, 2'd2, 1'b0, 1'b0, 8'd0, 4'd1, 4'd1});
        cfg_pin_en = 8'h65;
        do_reset();
        for (int i = 0; i < 8; i++) host_write(i, wordv(9, i));
        flip();
        run = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!ctrl_out[0]) break;
        end
        chk(ctrl_out == 8'h9A, "R5 mask low", 32'(ctrl_out), 32'h9A);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (ctrl_out[0]) break;
        end
        chk(ctrl_out == 8'hFF, "R5 mask high", 32'(ctrl_out), 32'hFF);
        run = 1'b0;
        cfg_pin_en = 8'hFF;
    endtask

    task automatic test_stop_resume();
        int base;
        logic [15:0] exp;
        set_cfg('{1'b1, 2'd2, 1'b0, 1'b0, 8'd0, 4'd1, 4'd1});
        do_reset();
        base = n_tx;
        for (int i = 0; i < 8; i++) host_write(i, wordv(7, i));
        flip();
        run = 1'b1;
        wait_tx(base + 3);
        run = 1'b0;
        repeat (30) @(negedge clk);
        @(posedge clk);
        chk(n_tx == base + 3, "R11 stop at boundary", 32'(n_tx - base), 32'h3);
        @(negedge clk);
        chk(ctrl_out == 8'hFF && !underrun, "R11 quiet stop", 32'({underrun, ctrl_out}), 32'hFF);
        run = 1'b1;
        wait_tx(base + 8);
        wait_stall();
        chk(underrun == 1'b1, "R10 underrun after buffer", 32'(underrun), 32'h1);
        for (int i = 0; i < 8; i++) host_write(i, wordv(8, i));
        flip();
        wait_tx(base + 9);
        chk(underrun == 1'b0, "R10 resume clears", 32'(underrun), 32'h0);
        wait_tx(base + 16);
        @(posedge clk);
        for (int k = 3; k < 16; k++) begin
            exp = (k < 8) ? wordv(7, k) : wordv(8, k - 8);
            chk(log_d[(base + k) % 64] == exp, "R11 R8 continued data",
                32'(log_d[(base + k) % 64]), 32'(exp));
        end
        @(negedge clk);
        run = 1'b0;
    endtask

    // ---------------- main ----------------
    initial begin
        rst = 1'b1;
        run = 1'b0;
        host_we = 1'b0;
        host_flip = 1'b0;
        host_addr = '0;
        host_raddr = '0;
        host_wdata = '0;
        test_reset();
        for (int s = 0; s < NSCEN; s++) run_scen(s);
        test_pin_mask();
        test_stop_resume();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule